// File: doc/BRIEF.md
# Two-Symbol Delivery Order Checker

This block sits next to a first-in first-out transport and checks that the transport delivers data in the order it was accepted, without losing or repeating anything. It keeps no full copy of the traffic. It watches two distinct marker values, called here the first and second watched symbols. One small state machine follows the accepted words and another follows the delivered words. Each tracks progress from "nothing seen", to "first symbol seen", to "first then second symbol seen". Every accepted word also stores the accept-side tracker state in a shadow queue whose depth matches the transport. Every delivered word is checked against the head of that queue. If the two differ, the stream was reordered, lost a watched word or delivered an extra one.

The checker also forwards the source stream into the transport through one register stage, so it controls what gets injected. It closes the run when the transport reports full or when a stop request arrives. From then on it forwards nothing more, and it raises a completion flag that stays set. Errors are flagged on a sticky output that only reset clears. The watched symbols and the queue depth are parameters, and the symbols are loaded into registers at reset.

Top module: `ord_deliv_check`

## Requirements
- R1: After a synchronous reset, `tp_push_o`, `done_o` and `err_o` are 0, and both trackers are in the nothing-seen state with the shadow queue empty.
- R2: A source word presented while the run is open (not done, transport not full, and not a watched symbol during a stop request) appears on `tp_push_o`/`tp_data_o` exactly one cycle later.
- R3: Each tracker moves from nothing-seen to first-seen only on the first symbol, and from first-seen to both-seen only on the second symbol. A second symbol that arrives before any first symbol does not advance it, and both-seen is kept for any later word.
- R4: When the delivered stream equals the forwarded stream in order, `err_o` stays 0.
- R5: Delivering a forwarded second symbol ahead of a forwarded first symbol sets `err_o` one cycle after that delivery.
- R6: Delivering a forwarded second symbol while an earlier forwarded first symbol was never delivered sets `err_o`.
- R7: A delivery while the shadow queue is empty (a duplicate or invented word) sets `err_o`.
- R8: Words other than the two watched symbols never move a tracker, so interleaving them with in-order traffic causes no error.
- R9: Once set, `err_o` stays 1 until reset.
- R10: A stop request in cycle t blocks a watched symbol presented in cycle t, still forwards any other value presented in cycle t, and makes `done_o` 1 from cycle t+1.
- R11: While `tp_full_i` is 1 no word is forwarded in the next cycle, and `done_o` becomes 1 one cycle later.
- R12: Once `done_o` is 1 it stays 1, and `tp_push_o` stays 0 until reset.
- R13: Reset after an error clears `err_o` and `done_o` and restores normal forwarding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid_i | input | 1 | Source word offered |
| src_data_i | input | DATA_W | Source word |
| stop_i | input | 1 | Request to close the run |
| tp_full_i | input | 1 | Transport reports full |
| tp_push_o | output | 1 | Registered push into the transport |
| tp_data_o | output | DATA_W | Registered word pushed into the transport |
| pop_valid_i | input | 1 | Transport delivers a word this cycle |
| pop_data_i | input | DATA_W | Delivered word |
| done_o | output | 1 | Sticky run-complete flag |
| err_o | output | 1 | Sticky ordering error flag |

## Verification
The hardest situation to reach is a delivery where the delivery-side tracker and the stored head state disagree only because of a position shift in the stream. The data values at both ends are legal symbols, and only their relative order is wrong. The bench plays the transport itself. For each scenario it chooses the delivered sequence deliberately: swapping the two watched symbols, dropping the first one, or replaying a word after the queue has drained. This puts the trackers into these states directly. It also covers the case where the second symbol comes before any first symbol, which must leave both trackers idle and raise no error.

// File: rtl/ord_chk_pkg.sv
package ord_chk_pkg;
  localparam int ST_W = 2;

  typedef enum logic [ST_W-1:0] {
    TRK_NONE  = 2'd0,
    TRK_FIRST = 2'd1,
    TRK_BOTH  = 2'd2
  } trk_st_t;

  function automatic trk_st_t trk_advance(trk_st_t cur, logic is_first, logic is_second);
    trk_st_t nx;
    nx = cur;
    if (cur == TRK_NONE && is_first) nx = TRK_FIRST;
    else if (cur == TRK_FIRST && is_second) nx = TRK_BOTH;
    return nx;
  endfunction
endpackage

// File: rtl/ord_sym_tracker.sv
module ord_sym_tracker
  import ord_chk_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic [DATA_W-1:0] sym_first_i,
  input  logic [DATA_W-1:0] sym_second_i,
  output trk_st_t           next_o
);
  trk_st_t st_q;

  always_comb begin
    next_o = st_q;
    if (step_i) next_o = trk_advance(st_q, word_i == sym_first_i, word_i == sym_second_i);
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= TRK_NONE;
    else     st_q <= next_o;
  end

  // R3: both-seen is never reached straight from nothing-seen
  a_r3_no_skip: assert property (@(posedge clk) disable iff (rst)
    st_q == TRK_NONE |=> st_q != TRK_BOTH);
  // R3: both-seen is kept
  a_r3_both_holds: assert property (@(posedge clk) disable iff (rst)
    st_q == TRK_BOTH |=> st_q == TRK_BOTH);
endmodule

// File: rtl/ord_shadow_q.sv
module ord_shadow_q #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             rd_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr_q, rptr_q;
  logic [CW-1:0]    cnt_q;
  logic             wr_ok, rd_ok;

  assign empty_o = (cnt_q == '0);
  assign rd_ok   = rd_i & ~empty_o;
  assign wr_ok   = wr_i & ((cnt_q != FULLC) | rd_ok);
  assign rdata_o = mem[rptr_q];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_ok) wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
      if (rd_ok) rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
      cnt_q <= cnt_q + CW'(wr_ok) - CW'(rd_ok);
    end
  end

  // R11: forwarding stops at full, so the shadow never has to refuse a write
  a_r11_shadow_room: assert property (@(posedge clk) disable iff (rst)
    wr_i |-> wr_ok);
  a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULLC);
endmodule

// File: rtl/ord_deliv_check.sv
module ord_deliv_check
  import ord_chk_pkg::*;
#(
  parameter int          DATA_W     = 8,
  parameter int          DEPTH      = 8,
  parameter logic [7:0]  SYM_FIRST  = 8'hA5,
  parameter logic [7:0]  SYM_SECOND = 8'h3C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              src_valid_i,
  input  logic [DATA_W-1:0] src_data_i,
  input  logic              stop_i,
  input  logic              tp_full_i,
  output logic              tp_push_o,
  output logic [DATA_W-1:0] tp_data_o,
  input  logic              pop_valid_i,
  input  logic [DATA_W-1:0] pop_data_i,
  output logic              done_o,
  output logic              err_o
);
  logic [DATA_W-1:0] sym_a_q, sym_b_q;
  logic              done_q, err_q, push_q;
  logic [DATA_W-1:0] data_q;
  logic              is_watched, accept, mismatch;
  trk_st_t           in_next, out_next;
  logic [ST_W-1:0]   head_st;
  logic              sh_empty;

  assign is_watched = (src_data_i == sym_a_q) | (src_data_i == sym_b_q);
  assign accept     = src_valid_i & ~done_q & ~tp_full_i & ~(stop_i & is_watched);

  always_ff @(posedge clk) begin
    if (rst) begin
      sym_a_q <= DATA_W'(SYM_FIRST);
      sym_b_q <= DATA_W'(SYM_SECOND);
      done_q  <= 1'b0;
      push_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      if (stop_i | tp_full_i) done_q <= 1'b1;
      push_q <= accept;
      if (accept) data_q <= src_data_i;
    end
  end

  ord_sym_tracker #(.DATA_W(DATA_W)) trk_in_i (
    .clk(clk), .rst(rst), .step_i(push_q), .word_i(data_q),
    .sym_first_i(sym_a_q), .sym_second_i(sym_b_q), .next_o(in_next)
  );

  ord_sym_tracker #(.DATA_W(DATA_W)) trk_out_i (
    .clk(clk), .rst(rst), .step_i(pop_valid_i), .word_i(pop_data_i),
    .sym_first_i(sym_a_q), .sym_second_i(sym_b_q), .next_o(out_next)
  );

  ord_shadow_q #(.DEPTH(DEPTH), .WIDTH(ST_W)) shadow_i (
    .clk(clk), .rst(rst), .wr_i(push_q), .wdata_i(in_next),
    .rd_i(pop_valid_i), .rdata_o(head_st), .empty_o(sh_empty)
  );

  assign mismatch = pop_valid_i & (sh_empty | (head_st != out_next));

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else if (mismatch) err_q <= 1'b1;
  end

  assign tp_push_o = push_q;
  assign tp_data_o = data_q;
  assign done_o    = done_q;
  assign err_o     = err_q;

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);
  a_r12_done_sticky: assert property (@(posedge clk) disable iff (rst)
    done_o |=> done_o);
  a_r12_no_push_after_done: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !tp_push_o);
  a_r10_stop_closes: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> done_o);
  a_r11_full_blocks: assert property (@(posedge clk) disable iff (rst)
    tp_full_i |=> !tp_push_o);
  a_r10_watched_blocked: assert property (@(posedge clk) disable iff (rst)
    stop_i && is_watched |=> !tp_push_o);
endmodule

// File: tb/ord_deliv_check_tb.sv
module ord_deliv_check_tb_top;
  localparam int DW = 8;
  localparam logic [7:0] SA = 8'hA5;
  localparam logic [7:0] SB = 8'h3C;

  logic clk = 1'b0;
  logic rst;
  logic src_valid_i, stop_i, tp_full_i, pop_valid_i;
  logic [DW-1:0] src_data_i, pop_data_i, tp_data_o;
  logic tp_push_o, done_o, err_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ord_deliv_check #(.DATA_W(DW), .DEPTH(8), .SYM_FIRST(SA), .SYM_SECOND(SB)) dut_i (
    .clk(clk), .rst(rst), .src_valid_i(src_valid_i), .src_data_i(src_data_i),
    .stop_i(stop_i), .tp_full_i(tp_full_i), .tp_push_o(tp_push_o), .tp_data_o(tp_data_o),
    .pop_valid_i(pop_valid_i), .pop_data_i(pop_data_i), .done_o(done_o), .err_o(err_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; src_valid_i = 0; src_data_i = '0; stop_i = 0; tp_full_i = 0;
    pop_valid_i = 0; pop_data_i = '0;
    @(negedge clk); @(negedge clk);
    rst = 0;
  endtask

  // offer one word; sampled one cycle later on the transport side
  task automatic push_word(logic [DW-1:0] d, string req);
    src_valid_i = 1; src_data_i = d;
    @(negedge clk);
    src_valid_i = 0;
    chk({req, " push"}, tp_push_o, 1);
    chk({req, " data"}, tp_data_o, d);
  endtask

  task automatic pop_word(logic [DW-1:0] d);
    pop_valid_i = 1; pop_data_i = d;
    @(negedge clk);
    pop_valid_i = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 push", tp_push_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 err", err_o, 0);
  endtask

  task automatic t_inorder();
    do_reset();
    push_word(8'h11, "R2"); push_word(SA, "R2"); push_word(8'h22, "R8");
    push_word(SB, "R2"); push_word(SA, "R3"); push_word(8'h33, "R8");
    @(negedge clk);
    pop_word(8'h11); pop_word(SA); pop_word(8'h22);
    pop_word(SB); pop_word(SA); pop_word(8'h33);
    chk("R4 in order no error", err_o, 0);
    chk("R8 other words no error", err_o, 0);
  endtask

  task automatic t_second_first();
    do_reset();
    push_word(SB, "R3"); push_word(SA, "R3"); push_word(SB, "R3");
    @(negedge clk);
    pop_word(SB);
    chk("R3 early second ignored", err_o, 0);
    pop_word(SA); pop_word(SB);
    chk("R3 in order after early second", err_o, 0);
  endtask

  task automatic t_swap();
    do_reset();
    push_word(SA, "R5"); push_word(SB, "R5");
    @(negedge clk);
    chk("R5 before swap", err_o, 0);
    pop_word(SB);
    chk("R5 swap detected", err_o, 1);
    pop_word(SA);
    chk("R9 sticky after swap", err_o, 1);
  endtask

  task automatic t_loss();
    do_reset();
    push_word(8'h44, "R6"); push_word(SA, "R6"); push_word(SB, "R6");
    @(negedge clk);
    pop_word(8'h44);
    chk("R6 clean before loss", err_o, 0);
    pop_word(SB);
    chk("R6 lost first symbol", err_o, 1);
  endtask

  task automatic t_dup();
    do_reset();
    push_word(SA, "R7");
    @(negedge clk);
    pop_word(SA);
    chk("R7 first delivery ok", err_o, 0);
    pop_word(SA);
    chk("R7 duplicate detected", err_o, 1);
    repeat (5) @(negedge clk);
    chk("R9 err held", err_o, 1);
    do_reset();
    chk("R13 err cleared", err_o, 0);
    chk("R13 done cleared", done_o, 0);
    push_word(8'h66, "R13");
  endtask

  task automatic t_stop();
    do_reset();
    stop_i = 1; src_valid_i = 1; src_data_i = SA;
    @(negedge clk);
    stop_i = 0; src_valid_i = 0;
    chk("R10 watched blocked", tp_push_o, 0);
    chk("R10 done set", done_o, 1);
    do_reset();
    stop_i = 1; src_valid_i = 1; src_data_i = 8'h77;
    @(negedge clk);
    stop_i = 0; src_valid_i = 0;
    chk("R10 other forwarded", tp_push_o, 1);
    chk("R10 other data", tp_data_o, 8'h77);
    src_valid_i = 1; src_data_i = 8'h12;
    @(negedge clk);
    src_valid_i = 0;
    chk("R12 no push after done", tp_push_o, 0);
    repeat (3) @(negedge clk);
    chk("R12 done held", done_o, 1);
  endtask

  task automatic t_full();
    do_reset();
    tp_full_i = 1; src_valid_i = 1; src_data_i = 8'h19;
    @(negedge clk);
    tp_full_i = 0; src_valid_i = 1; src_data_i = 8'h1A;
    chk("R11 blocked at full", tp_push_o, 0);
    chk("R11 done set", done_o, 1);
    @(negedge clk);
    src_valid_i = 0;
    chk("R12 blocked after full", tp_push_o, 0);
  endtask

  initial begin
    rst = 1;
    t_reset();
    t_inorder();
    t_second_first();
    t_swap();
    t_loss();
    t_dup();
    t_stop();
    t_full();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule